// File: doc/BRIEF.md
# Mask-Steered Partitioned Data Cache

This block is a small write-back data cache made of several equal direct-mapped partitions. Together they hold as much as one unified cache would. Each processor access carries a partition mask. The mask picks which partitions may take a new copy of the block on a miss. In the normal case it also picks which partitions are looked up. Partitions outside the probe set leave their tag and data arrays unread. This is where the energy saving comes from.

A per-access probe-all flag widens the lookup to every partition without widening the replacement choice. Software sets this flag when a block may sit in a partition outside the current mask, so that the same block is never loaded into two partitions.

On a miss the victim comes only from the masked partitions. An invalid line among them is taken first. Otherwise a per-set round-robin pointer picks the line. A dirty victim goes to memory before the refill. Memory traffic is one word per line over a request/acknowledge port.

Top module: `pcache`

## Requirements
- R1: After reset, `reqReady` is 1 and `respValid`, `memReq` and `wayRead` are 0. Every line is invalid, so the first access to any address misses.
- R2: An access accepted on a clock edge (`reqValid` and `reqReady`) shows its probe set on `wayRead` for the following cycle only. Bit w stands for partition w. With the probe-all flag clear and a non-zero mask, the probe set equals the mask, and unmasked partitions are not read.
- R3: With `reqProbeAll` set, all partitions are probed, whatever the mask.
- R4: A mask of all zeros is treated as all ones, for both probing and replacement.
- R5: A hit in any probed partition returns that partition's data with `respHit`=1, even when the partition is outside the mask. A hit causes no memory traffic.
- R6: On a miss, the line installed for the address lies in a partition whose mask bit is set.
- R7: Among the candidate partitions, an invalid line at the request's set index is chosen first. If more than one is invalid, the lowest-numbered one is chosen.
- R8: When all candidates are valid, the victim is the first candidate found scanning upward and wrapping from that set's pointer. After any install, the pointer becomes victim+1 mod K. All pointers start at 0.
- R9: A store hit updates the line and marks it dirty, with no memory write. A dirty victim is written back (its address and data) before the refill read is issued.
- R10: A store miss refills the line, then merges the store data and leaves the line dirty. A clean victim is dropped without a write.
- R11: A hit responds in the cycle after acceptance. A miss responds in the cycle of the refill acknowledge. `respValid` lasts one cycle and `reqReady` returns the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqReady | output | 1 | Cache idle, request accepted |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | AW | Word address; low bits are the set index |
| reqWdata | input | DW | Store data |
| reqMask | input | K | Partition mask, bit w = partition w |
| reqProbeAll | input | 1 | Probe every partition |
| respValid | output | 1 | Access complete |
| respHit | output | 1 | Completion was a hit |
| respData | output | DW | Line contents after the access |
| wayRead | output | K | Partitions whose arrays are read this cycle |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | 1 = write-back, 0 = refill read |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Write-back data |
| memAck | input | 1 | Memory acknowledge, one cycle |
| memRdata | input | DW | Refill data, valid with memAck |

## Verification
The bench aims at the cases where mask and probe set differ. If the probe-all flag were ignored, a hit outside the mask would turn into a needless refill. If a zero mask were taken literally, the cache would find no victim. If victims were taken outside the mask, a later masked lookup would miss on a line that should be resident.

Round-robin order is checked across several fills of one set. A pointer that was shared between sets, or that failed to skip unmasked partitions, would evict the wrong line. That error shows up as a wrong write-back address or stale data.

Dirty handling is checked by reloading evicted stores. A design that lost the write-back or ordered it after the refill would return old memory contents.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WB, ST_FILL} pcState_t;

  typedef struct packed {
    logic latch;    // capture request
    logic look;     // read tag/data of probe set
    logic hitUpd;   // apply store on hit
    logic wb;       // write-back in progress
    logic fill;     // refill in progress
    logic install;  // write refilled line
  } pcStrobe_t;
endpackage

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hit,
  input  logic      vicDirty,
  input  logic      memAck,
  output pcStrobe_t stb,
  output logic      reqReady,
  output logic      respValid,
  output logic      respHit
);
  pcState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    respValid = 1'b0;
    respHit   = 1'b0;
    reqReady  = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        stb.latch = reqValid;
        if (reqValid) nextState = ST_LOOK;
      end
      ST_LOOK: begin
        stb.look = 1'b1;
        if (hit) begin
          stb.hitUpd = 1'b1;
          respValid  = 1'b1;
          respHit    = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          nextState = vicDirty ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        stb.wb = 1'b1;
        if (memAck) nextState = ST_FILL;
      end
      ST_FILL: begin
        stb.fill = 1'b1;
        if (memAck) begin
          stb.install = 1'b1;
          respValid   = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pcache_dp.sv
module pcache_dp
  import pcache_pkg::*;
#(
  parameter int K    = 4,
  parameter int SETS = 4,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  pcStrobe_t     stb,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [K-1:0]  reqMask,
  input  logic          reqProbeAll,
  input  logic [DW-1:0] memRdata,
  output logic          hit,
  output logic          vicDirty,
  output logic [DW-1:0] respData,
  output logic [K-1:0]  wayRead,
  output logic          memReq,
  output logic          memWrite,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;
  localparam int PW = $clog2(K);

  logic [AW-1:0] rAddr;
  logic [DW-1:0] rWdata;
  logic          rWrite;
  logic [K-1:0]  rProbe, rRepl;

  logic [TW-1:0] tagArr [K][SETS];
  logic [DW-1:0] datArr [K][SETS];
  logic [K-1:0]  vArr   [SETS];
  logic [K-1:0]  dArr   [SETS];
  logic [PW-1:0] rrArr  [SETS];

  logic [IW-1:0] idx;
  logic [TW-1:0] rTag;
  logic [K-1:0]  hitVec;
  logic [PW-1:0] hitWay, vic;

  assign idx  = rAddr[IW-1:0];
  assign rTag = rAddr[AW-1:IW];

  // probe set and hit detection, one comparator per partition
  for (genvar w = 0; w < K; w++) begin : g_cmp
    assign hitVec[w] = rProbe[w] & vArr[idx][w] & (tagArr[w][idx] == rTag);
  end
  assign hit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < K; w++)
      if (hitVec[w]) hitWay = PW'(w);
  end

  // victim: lowest invalid candidate, else round-robin from set pointer
  always_comb begin
    logic found;
    found = 1'b0;
    vic   = '0;
    for (int w = 0; w < K; w++)
      if (!found && rRepl[w] && !vArr[idx][w]) begin
        vic   = PW'(w);
        found = 1'b1;
      end
    for (int i = 0; i < K; i++) begin
      int j;
      j = (int'(rrArr[idx]) + i) % K;
      if (!found && rRepl[j]) begin
        vic   = PW'(j);
        found = 1'b1;
      end
    end
  end
  assign vicDirty = vArr[idx][vic] & dArr[idx][vic];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rAddr  <= '0;
      rWdata <= '0;
      rWrite <= 1'b0;
      rProbe <= '0;
      rRepl  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vArr[s]  <= '0;
        dArr[s]  <= '0;
        rrArr[s] <= '0;
        for (int w = 0; w < K; w++) begin
          tagArr[w][s] <= '0;
          datArr[w][s] <= '0;
        end
      end
    end else begin
      if (stb.latch) begin
        rAddr  <= reqAddr;
        rWdata <= reqWdata;
        rWrite <= reqWrite;
        rRepl  <= (reqMask == '0) ? '1 : reqMask;
        rProbe <= (reqProbeAll || reqMask == '0) ? '1 : reqMask;
      end
      if (stb.hitUpd && rWrite) begin
        datArr[hitWay][idx] <= rWdata;
        dArr[idx][hitWay]   <= 1'b1;
      end
      if (stb.install) begin
        tagArr[vic][idx] <= rTag;
        datArr[vic][idx] <= rWrite ? rWdata : memRdata;
        vArr[idx][vic]   <= 1'b1;
        dArr[idx][vic]   <= rWrite;
        rrArr[idx]       <= PW'((int'(vic) + 1) % K);
      end
    end
  end

  assign wayRead  = stb.look ? rProbe : '0;
  assign memReq   = stb.wb | stb.fill;
  assign memWrite = stb.wb;
  assign memAddr  = stb.wb ? {tagArr[vic][idx], idx} : rAddr;
  assign memWdata = datArr[vic][idx];
  assign respData = rWrite ? rWdata :
                    (stb.install ? memRdata : datArr[hitWay][idx]);
endmodule

// File: rtl/pcache.sv
module pcache
  import pcache_pkg::*;
#(
  parameter int K    = 4,
  parameter int SETS = 4,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [K-1:0]  reqMask,
  input  logic          reqProbeAll,
  output logic          respValid,
  output logic          respHit,
  output logic [DW-1:0] respData,
  output logic [K-1:0]  wayRead,
  output logic          memReq,
  output logic          memWrite,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata
);
  pcStrobe_t stb;
  logic      hit, vicDirty;

  pcache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .vicDirty(vicDirty), .memAck(memAck), .stb(stb),
    .reqReady(reqReady), .respValid(respValid), .respHit(respHit)
  );

  pcache_dp #(.K(K), .SETS(SETS), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqProbeAll(reqProbeAll), .memRdata(memRdata), .hit(hit),
    .vicDirty(vicDirty), .respData(respData), .wayRead(wayRead),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata)
  );
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(parameter int K = 4) (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic         reqReady,
  input logic         respValid,
  input logic         respHit,
  input logic         memReq,
  input logic         memWrite,
  input logic         memAck,
  input logic [K-1:0] wayRead
);
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);  // R11
  AST_READY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> reqReady);  // R11
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> !memReq);  // R5
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && memAck) |=> (memReq && !memWrite));  // R9
  AST_PROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (wayRead != '0));  // R2
  AST_PROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (wayRead != '0) |=> (wayRead == '0));  // R2
endmodule

bind pcache pcache_chk #(.K(K)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respHit(respHit), .memReq(memReq),
  .memWrite(memWrite), .memAck(memAck), .wayRead(wayRead)
);

// File: tb/pcache_test.sv
module pcache_test;
  localparam int K = 4, SETS = 4, AW = 12, DW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqProbeAll = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [K-1:0]  reqMask = '0;
  logic reqReady, respValid, respHit, memReq, memWrite;
  logic [DW-1:0] respData, memWdata;
  logic [K-1:0]  wayRead;
  logic [AW-1:0] memAddr;
  logic memAck = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #2.5 clk = ~clk;

  pcache #(.K(K), .SETS(SETS), .AW(AW), .DW(DW)) uut (.*);

  int tests = 0, fails = 0, cycles = 0;
  int wbCount = 0, ackCnt = 0;
  logic [AW-1:0] lastWbA;
  logic [DW-1:0] lastWbD;
  logic [DW-1:0] mem [int];

  // behavioural reference state
  bit   mV [K][SETS];
  bit   mD [K][SETS];
  int   mT [K][SETS];
  logic [DW-1:0] mDat [K][SETS];
  int   mRr [SETS];

  function automatic logic [DW-1:0] rd(input int a);
    return mem.exists(a) ? mem[a] : {20'hC0DE5, 12'(a)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory: acknowledge two cycles after a request is seen
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rstN) begin memAck = 1'b0; ackCnt = 0; end
    else if (memAck) begin memAck = 1'b0; ackCnt = 0; end
    else if (memReq) begin
      ackCnt++;
      if (ackCnt == 2) begin
        memAck = 1'b1;
        if (memWrite) begin
          mem[int'(memAddr)] = memWdata;
          wbCount++; lastWbA = memAddr; lastWbD = memWdata;
        end else memRdata = rd(int'(memAddr));
      end
    end
  end

  task automatic acc(input bit w, input int a, input logic [DW-1:0] d,
                     input logic [K-1:0] m, input bit pa, input string req);
    int idx = a % SETS, tg = a / SETS, hitW = -1, vic = -1, wb0;
    logic [K-1:0] probe, repl;
    bit expWb = 0;
    logic [AW-1:0] expWbA = '0;
    logic [DW-1:0] expWbD = '0, expData;
    repl  = (m == 0) ? '1 : m;
    probe = (pa || m == 0) ? '1 : m;
    for (int i = 0; i < K; i++)
      if (probe[i] && mV[i][idx] && mT[i][idx] == tg) hitW = i;
    if (hitW >= 0) begin
      expData = w ? d : mDat[hitW][idx];
      if (w) begin mDat[hitW][idx] = d; mD[hitW][idx] = 1; end
    end else begin
      for (int i = K - 1; i >= 0; i--) if (repl[i] && !mV[i][idx]) vic = i;
      if (vic < 0)
        for (int i = K - 1; i >= 0; i--)
          if (repl[(mRr[idx] + i) % K]) vic = (mRr[idx] + i) % K;
      expWb = mV[vic][idx] && mD[vic][idx];
      expWbA = AW'(mT[vic][idx] * SETS + idx);
      expWbD = mDat[vic][idx];
      expData = w ? d : ((expWb && int'(expWbA) == a) ? expWbD : rd(a));
      mV[vic][idx] = 1; mD[vic][idx] = w; mT[vic][idx] = tg;
      mDat[vic][idx] = expData; mRr[idx] = (vic + 1) % K;
    end
    @(negedge clk);
    while (!reqReady && cycles < 100000) @(negedge clk);
    reqValid = 1; reqWrite = w; reqAddr = AW'(a); reqWdata = d;
    reqMask = m; reqProbeAll = pa;
    wb0 = wbCount;
    @(negedge clk);
    reqValid = 0;
    check(wayRead == probe, "R2", "probe set", DW'(wayRead), DW'(probe));
    while (!respValid && cycles < 100000) @(negedge clk);
    check(respHit == (hitW >= 0), req, "hit flag", DW'(respHit), DW'(hitW >= 0));
    check(respData == expData, req, "data", respData, expData);
    check((wbCount - wb0) == int'(expWb), "R9", "write-back count",
          DW'(wbCount - wb0), DW'(expWb));
    if (expWb) begin
      check(lastWbA == expWbA, "R9", "write-back address", DW'(lastWbA), DW'(expWbA));
      check(lastWbD == expWbD, "R9", "write-back data", lastWbD, expWbD);
    end
  endtask

  initial begin
    automatic logic [15:0] lfsr = 16'hACE1;
    for (int w = 0; w < K; w++) for (int s = 0; s < SETS; s++) begin
      mV[w][s] = 0; mD[w][s] = 0; mT[w][s] = 0; mDat[w][s] = '0;
    end
    for (int s = 0; s < SETS; s++) mRr[s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", DW'(reqReady), 1);
    check(respValid == 1'b0, "R1", "respValid", DW'(respValid), 0);
    check(memReq == 1'b0, "R1", "memReq", DW'(memReq), 0);
    check(wayRead == '0, "R1", "wayRead", DW'(wayRead), 0);
    acc(0, 'h010, 0, 4'b0001, 0, "R1");          // cold miss -> way0 (R7)
    acc(0, 'h010, 0, 4'b0001, 0, "R2");          // hit, only way0 read
    acc(0, 'h010, 0, 4'b0010, 1, "R3");          // probe-all hit outside mask (R5)
    acc(0, 'h020, 0, 4'b0000, 0, "R4");          // zero mask: all ways, lowest invalid
    acc(1, 'h030, 32'h1111_2222, 4'b1100, 0, "R10"); // store miss -> way2 dirty
    acc(0, 'h040, 0, 4'b1000, 0, "R6");          // forced into way3
    acc(1, 'h010, 32'hAAAA_5555, 4'b0001, 0, "R9");  // store hit, dirty
    acc(0, 'h050, 0, 4'b0101, 0, "R8");          // rr=0 -> way0, dirty wb
    acc(0, 'h060, 0, 4'b0101, 0, "R8");          // rr=1 -> way2, dirty wb
    acc(0, 'h070, 0, 4'b0000, 0, "R8");          // rr=3 -> way3
    acc(0, 'h010, 0, 4'b1111, 0, "R9");          // reload written-back store
    acc(0, 'h040, 0, 4'b0000, 0, "R6");          // evicted line misses
    acc(0, 'h011, 0, 4'b0010, 0, "R7");          // other set, own pointer
    acc(0, 'h011, 0, 4'b0100, 1, "R5");          // hit in way1 outside mask
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc(lfsr[0], {26'd0, lfsr[7:2]} + 'h100, {lfsr, ~lfsr},
          lfsr[11:8], 1, "R6");
      if (cycles >= 100000) break;
    end
    if (cycles >= 100000) check(0, "R11", "watchdog expired", DW'(cycles), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++; tests++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule